// File: doc/BRIEF.md
# Fractional-Capable 8x8 Multiplier Unit

This unit forms the 16-bit product of two 8-bit operands for a small processor core. One mode input chooses whether each operand is read as a two's-complement or an unsigned number. It also chooses whether the product is left as an integer or scaled for 1.7 fixed-point arithmetic. In the fixed-point case the result is shifted left by one place, so that the product of two 1.7 values comes out in 1.15 format.

The core pulses `start` with the operands and mode. The unit captures them on that clock edge and spends one further cycle forming the product. It then presents the 16-bit result together with a zero flag and a carry flag, and pulses `done` for one cycle. The core writes the high byte of `product` into register 1 and the low byte into register 0. It copies the two flags into its status word and leaves the other flags unchanged. The unit does no register-file writeback or decode itself. A `start` that arrives while a multiply is in progress is dropped.

Top module: `mul8x8_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first completion, `product`, `flag_z`, `flag_c` and `done` are all zero.
- R2: A `start` sampled high on a clock edge while the unit is idle makes `done` high for exactly one cycle, two cycles after the cycle in which `start` was high. The new `product` and flags appear in that same cycle.
- R3: The unit is busy in the cycle after an accepted `start`. A `start` sampled in that cycle is ignored: it produces no second `done` and does not change the result of the multiply in progress. A `start` in the `done` cycle is accepted.
- R4: Mode encoding: `mode[2]`=1 selects fractional scaling. `mode[1:0]` selects the signedness: 00 is unsigned×unsigned, 01 is signed×signed, 10 is op_a signed × op_b unsigned, and 11 behaves as 00.
- R5: In unsigned×unsigned mode, `product` is the exact unsigned product, for example 0xFF×0xFF = 0xFE01.
- R6: In signed×signed mode, `product` is the 16-bit two's-complement product, for example 0x80×0x80 = 0x4000 and 0xFF×0x01 = 0xFFFF.
- R7: In signed×unsigned mode, op_a is sign-extended and op_b is zero-extended, for example 0xFF×0xFF = 0xFF01.
- R8: In the fractional modes, `product` is the 16-bit raw product shifted left by one bit, with a zero in bit 0. The raw bit 15 is discarded.
- R9: `flag_c` equals bit 15 of the raw product, taken before any fractional shift.
- R10: `flag_z` is 1 exactly when the 16-bit value presented on `product` is zero.
- R11: Between completions, `product`, `flag_z` and `flag_c` hold their last values, whatever happens on the operand and mode inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply with the present operands and mode |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| mode | input | 3 | Fractional select (bit 2) and signedness (bits 1:0) |
| product | output | 16 | Result; high byte goes to register 1, low byte to register 0 |
| flag_z | output | 1 | Zero flag for the status word |
| flag_c | output | 1 | Carry flag for the status word |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The bench drives the extreme operands in every mode, including 0x80 and 0xFF. A design that extended the wrong operand in the mixed mode, or zero-extended a signed one, returns products that differ in the high byte there. Fractional cases with raw bit 15 set separate a carry taken after the shift from one taken before it. A zero operand in a fractional mode shows whether Z is computed on the shifted value. A `start` held for two cycles with fresh operands in the second cycle catches a unit that re-triggers while busy, because such a unit produces a second `done` or a corrupted product. A delayed or stretched `done` is caught by sampling the cycles on both sides of the expected pulse.

// File: rtl/mul8x8_unit.sv
module mul8x8_unit #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [2:0]     mode,
  output logic [2*W-1:0] product,
  output logic           flag_z,
  output logic           flag_c,
  output logic           done
);
  localparam int PW = 2 * W;

  logic           busy;
  logic [W-1:0]   a_q, b_q;
  logic [2:0]     m_q;
  logic           a_sgn, b_sgn;
  logic [W:0]     a_ext, b_ext;
  logic [PW+1:0]  full;
  logic [PW-1:0]  raw, fin;

  assign a_sgn = (m_q[1:0] == 2'b01) || (m_q[1:0] == 2'b10);
  assign b_sgn = (m_q[1:0] == 2'b01);
  assign a_ext = {a_sgn & a_q[W-1], a_q};
  assign b_ext = {b_sgn & b_q[W-1], b_q};
  assign full  = PW'(0) + ($signed(a_ext) * $signed(b_ext));
  assign raw   = full[PW-1:0];
  assign fin   = m_q[2] ? {raw[PW-2:0], 1'b0} : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      m_q     <= '0;
      product <= '0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        product <= fin;
        flag_z  <= (fin == '0);
        flag_c  <= raw[PW-1];
        done    <= 1'b1;
        busy    <= 1'b0;
      end else if (start) begin
        a_q  <= op_a;
        b_q  <= op_b;
        m_q  <= mode;
        busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mul8x8_unit_chk.sv
module mul8x8_unit_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [2:0]     mode,
  input logic [2*W-1:0] product,
  input logic           flag_z,
  input logic           flag_c,
  input logic           done,
  input logic           busy
);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));

  a_r3_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r8_frac_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mode[2], 2)) |-> (product[0] == 1'b0));

  a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == (product == '0)));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(product) && $stable(flag_z) && $stable(flag_c))));
endmodule

bind mul8x8_unit mul8x8_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_mul8x8_unit.sv
module tb_mul8x8_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op_a = '0, op_b = '0;
  logic [2:0]  mode = '0;
  logic [15:0] product;
  logic        flag_z, flag_c, done;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  mul8x8_unit dut (.clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a),
    .op_b(op_b), .mode(mode), .product(product), .flag_z(flag_z),
    .flag_c(flag_c), .done(done));

  function automatic logic [17:0] model(input logic [7:0] a, b, input logic [2:0] m);
    int ia, ib, r;
    logic [15:0] raw, fin;
    logic sa, sb;
    sa = (m[1:0] == 2'b01) || (m[1:0] == 2'b10);
    sb = (m[1:0] == 2'b01);
    ia = sa ? int'($signed(a)) : int'(a);
    ib = sb ? int'($signed(b)) : int'(b);
    r = ia * ib;
    raw = r[15:0];
    fin = m[2] ? {raw[14:0], 1'b0} : raw;
    return {(fin == 16'h0), raw[15], fin};
  endfunction

  task automatic check(input string tag, input logic ok, input logic [31:0] got, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [7:0] a, b, input logic [2:0] m);
    logic [17:0] e;
    e = model(a, b, m);
    @(negedge clk);
    op_a = a; op_b = b; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_a = ~a; op_b = ~b;
    check({tag, " R2 early done"}, done == 1'b0, 32'(done), 32'd0);
    @(negedge clk);
    check({tag, " R2/R9/R10 result"}, done && ({flag_z, flag_c, product} == e),
          {13'd0, done, flag_z, flag_c, product}, {13'd0, 1'b1, e});
    @(negedge clk);
    check({tag, " R2 pulse width"}, done == 1'b0, 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset", {product, flag_z, flag_c, done} == '0,
          32'({product, flag_z, flag_c, done}), 32'd0);
  endtask

  task automatic t_corners;
    run_op("R5 uu max", 8'hFF, 8'hFF, 3'b000);
    run_op("R5 uu mid", 8'h80, 8'h02, 3'b000);
    run_op("R6 ss min", 8'h80, 8'h80, 3'b001);
    run_op("R6 ss neg", 8'hFF, 8'h01, 3'b001);
    run_op("R6 ss mix", 8'h7F, 8'h80, 3'b001);
    run_op("R7 su", 8'hFF, 8'hFF, 3'b010);
    run_op("R7 su pos", 8'h7F, 8'hFF, 3'b010);
    run_op("R4 code 11 as uu", 8'hFF, 8'h80, 3'b011);
    run_op("R8 frac uu carry", 8'hFF, 8'hFF, 3'b100);
    run_op("R8 frac ss", 8'h80, 8'h80, 3'b101);
    run_op("R8 frac su", 8'h80, 8'hFF, 3'b110);
    run_op("R10 frac zero", 8'h00, 8'h9A, 3'b101);
    run_op("R10 uu zero", 8'h37, 8'h00, 3'b000);
    run_op("R9 carry ss neg", 8'h81, 8'h01, 3'b001);
  endtask

  task automatic t_random;
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 120; i++)
        run_op("R4 sweep", 8'($urandom), 8'($urandom), 3'(m));
  endtask

  task automatic t_busy;
    logic [17:0] e;
    e = model(8'h12, 8'h34, 3'b000);
    @(negedge clk);
    op_a = 8'h12; op_b = 8'h34; mode = 3'b000; start = 1'b1;
    @(negedge clk);
    op_a = 8'hFF; op_b = 8'hFF; mode = 3'b101;
    @(negedge clk);
    start = 1'b0;
    check("R3 first result", done && ({flag_z, flag_c, product} == e),
          {13'd0, done, flag_z, flag_c, product}, {13'd0, 1'b1, e});
    @(negedge clk);
    check("R3 no second done", done == 1'b0, 32'(done), 32'd0);
    @(negedge clk);
    check("R3 still no done", !done && product == e[15:0],
          {15'd0, done, product}, {16'd0, e[15:0]});
  endtask

  task automatic t_hold;
    logic [15:0] p;
    run_op("R11 setup", 8'h0C, 8'h0D, 3'b000);
    p = product;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      op_a = 8'(i * 37); op_b = 8'(i * 11); mode = 3'(i);
    end
    check("R11 hold", product == p && !done, {15'd0, done, product}, {16'd0, p});
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_corners();
    t_busy();
    t_hold();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule